// File: doc/BRIEF.md
# Adapter Configuration Store

This block keeps the 32-byte configuration image of a host adapter and answers
block commands from the host. A command carries an opcode, a starting byte
offset and a byte count. A store command then takes in that many data bytes on
a write stream. A fetch command gives out that many bytes on a read stream. Each
command ends with a one-cycle completion pulse that carries a status byte. A
command whose span runs past the end of the image is refused, and no byte moves.
An opcode the block does not know is refused in the same way.

At reset the image holds fixed bit-packed defaults. Some bytes are decoded
continuously into live configuration outputs: the adapter's bus ID, an
alternate floppy-address select, the interrupt number, the DMA channel, the
feature flag byte, the transfer-speed code with its rate in tenths of MB/s, and
the parity, termination and boot-time bus-reset enables. The image is held in
registers. No serial memory timing is modelled.

Top module: `cfg_store`

## Requirements
- R1: After reset the image holds byte0=0x07, byte1=0x66, byte2=0x22, byte6=0x06, and 0x00 in every other byte (byte3 included).
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is high only while no command is in progress.
- R3: A command whose offset plus length is above 32 finishes with status 0xFF. It raises neither wr_ready nor rd_valid, and it leaves the image unchanged.
- R4: Opcode 0x22 with an in-range span takes in length bytes, one per wr_valid/wr_ready handshake, and stores them at offset, offset+1, and so on. It finishes with status 0x00.
- R5: Opcode 0x23 with an in-range span gives out the bytes from offset upward, one per rd_valid/rd_ready handshake. rd_data is held stable while rd_valid is high and rd_ready is low. The command finishes with status equal to the length.
- R6: Any opcode other than 0x22 or 0x23 finishes with status 0xFF, moves no data and leaves the image unchanged.
- R7: done is high for exactly one cycle per command, with status valid in that cycle. It comes in the cycle after the last data handshake, or in the cycle after acceptance when no data moves.
- R8: An in-range command with length 0 moves no data and finishes with status 0x00, for both opcodes.
- R9: bus_id equals byte0 bits [2:0]. alt_floppy equals byte0 bit 7.
- R10: irq_num equals byte1 bits [3:0] plus 9. dma_chan equals byte1 bits [7:4].
- R11: Speed code byte3 maps to speed_tenths as follows: 0xFF→33, 0x00→50, 0x04→56, 0x01→67, 0x02→80, 0x03→100. speed_known is 1 for these codes. Any other code gives speed_tenths=0 and speed_known=0.
- R12: feat_flags equals byte2. From byte6, bit 0 drives parity_en, bit 1 drives term_en and bit 2 drives boot_bus_reset.
- R13: The decoded outputs show a stored byte in the cycle after the edge of its write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 8 | Opcode (0x22 store, 0x23 fetch) |
| cmd_off | input | 8 | Starting byte offset |
| cmd_len | input | 8 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Completion pulse |
| status | output | 8 | Completion status, valid with done |
| bus_id | output | 3 | Adapter bus ID |
| alt_floppy | output | 1 | Alternate floppy address select |
| irq_num | output | 5 | Interrupt number |
| dma_chan | output | 4 | DMA channel |
| feat_flags | output | 8 | Feature flag byte |
| speed_code | output | 8 | Raw speed code |
| speed_tenths | output | 7 | Transfer rate in 0.1 MB/s |
| speed_known | output | 1 | Speed code is one of the listed codes |
| parity_en | output | 1 | Parity check enable |
| term_en | output | 1 | Host termination enable |
| boot_bus_reset | output | 1 | Reset the bus at boot |

## Verification
A wrong pointer or count in the sequencer shows up at the read stream. A later
fetch of the same span gives a shifted or short byte sequence. The status or
done cycle of the command itself also moves, because the bench knows in which
cycle done must come. A stray write strobe damages a byte of the image. If that
byte is decoded, the decoded outputs change one cycle later. If it is not, the
damage shows on the next fetch of that span. Each random command is followed by
a check of every decoded output against the bench's own copy of the image, so
damage is caught within one command.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  localparam logic [7:0] OP_STORE = 8'h22;
  localparam logic [7:0] OP_FETCH = 8'h23;
  localparam logic [7:0] ST_REFUSE = 8'hFF;
  localparam logic [7:0] ST_OK     = 8'h00;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_READ  = 2'd2,
    SEQ_END   = 2'd3
  } seq_state_t;

  // True when [off, off+len) lies inside an image of 'limit' bytes.
  function automatic logic span_fits(input logic [7:0] off, input logic [7:0] len,
                                     input int unsigned limit);
    logic [8:0] last;
    last = {1'b0, off} + {1'b0, len};
    return (last <= 9'(limit));
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_STORE) || (op == OP_FETCH);
  endfunction

  // Reset image: bus ID 7, IRQ code 6 with DMA 6, flags and enables set.
  function automatic logic [7:0] default_byte(input int unsigned idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'h66;
      2:       return 8'h22;
      6:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] irq_from_code(input logic [3:0] code);
    return 5'(code) + 5'd9;
  endfunction

  function automatic logic [6:0] speed_rate(input logic [7:0] code);
    case (code)
      8'hFF:   return 7'd33;
      8'h00:   return 7'd50;
      8'h04:   return 7'd56;
      8'h01:   return 7'd67;
      8'h02:   return 7'd80;
      8'h03:   return 7'd100;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic speed_listed(input logic [7:0] code);
    return (code == 8'hFF) || (code <= 8'h04);
  endfunction

endpackage

// File: rtl/cfg_store_seq.sv
module cfg_store_seq
  import cfg_store_pkg::*;
#(
  parameter int unsigned NBYTES = 32,
  localparam int unsigned AW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_op,
  input  logic [7:0]    cmd_off,
  input  logic [7:0]    cmd_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          done,
  output logic [7:0]    status,
  output logic          cmd_fire,
  output logic          beat_fire,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);

  seq_state_t       state_q;
  logic [AW-1:0]    ptr_q;
  logic [7:0]       remain_q;
  logic [7:0]       status_q;
  logic             cmd_ok;
  logic             last_beat;

  assign cmd_ready = (state_q == SEQ_IDLE);
  assign wr_ready  = (state_q == SEQ_WRITE);
  assign rd_valid  = (state_q == SEQ_READ);
  assign done      = (state_q == SEQ_END);
  assign status    = status_q;

  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_ok    = op_known(cmd_op) && span_fits(cmd_off, cmd_len, NBYTES);
  assign beat_fire = (wr_ready && wr_valid) || (rd_valid && rd_ready);
  assign last_beat = (remain_q == 8'd1);
  assign mem_we    = wr_ready && wr_valid;
  assign mem_addr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      ptr_q    <= '0;
      remain_q <= '0;
      status_q <= ST_OK;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (cmd_fire) begin
            if (!cmd_ok) begin
              status_q <= ST_REFUSE;
              state_q  <= SEQ_END;
            end else if (cmd_len == 8'd0) begin
              status_q <= ST_OK;
              state_q  <= SEQ_END;
            end else begin
              ptr_q    <= cmd_off[AW-1:0];
              remain_q <= cmd_len;
              status_q <= (cmd_op == OP_STORE) ? ST_OK : cmd_len;
              state_q  <= (cmd_op == OP_STORE) ? SEQ_WRITE : SEQ_READ;
            end
          end
        end
        SEQ_WRITE, SEQ_READ: begin
          if (beat_fire) begin
            if (last_beat) begin
              state_q <= SEQ_END;
            end else begin
              remain_q <= remain_q - 8'd1;
              ptr_q    <= ptr_q + AW'(1);
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_store_image.sv
module cfg_store_image
  import cfg_store_pkg::*;
#(
  parameter int unsigned NBYTES = 32,
  localparam int unsigned AW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    tap_id,
  output logic [7:0]    tap_chan,
  output logic [7:0]    tap_flags,
  output logic [7:0]    tap_speed,
  output logic [7:0]    tap_bus
);

  logic [7:0] cells [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= default_byte(g);
      else if (we && (addr == AW'(g)))
        cells[g] <= wdata;
    end
  end

  assign rdata     = cells[addr];
  assign tap_id    = cells[0];
  assign tap_chan  = cells[1];
  assign tap_flags = cells[2];
  assign tap_speed = cells[3];
  assign tap_bus   = cells[6];

endmodule

// File: rtl/cfg_store_decode.sv
module cfg_store_decode
  import cfg_store_pkg::*;
(
  input  logic [7:0] id_byte,
  input  logic [7:0] chan_byte,
  input  logic [7:0] flag_byte,
  input  logic [7:0] speed_byte,
  input  logic [2:0] bus_bits,
  output logic [2:0] bus_id,
  output logic       alt_floppy,
  output logic [4:0] irq_num,
  output logic [3:0] dma_chan,
  output logic [7:0] feat_flags,
  output logic [7:0] speed_code,
  output logic [6:0] speed_tenths,
  output logic       speed_known,
  output logic       parity_en,
  output logic       term_en,
  output logic       boot_bus_reset
);

  logic [3:0] unused_id;
  assign unused_id = id_byte[6:3];

  assign bus_id         = id_byte[2:0];
  assign alt_floppy     = id_byte[7] | (&unused_id & 1'b0);
  assign irq_num        = irq_from_code(chan_byte[3:0]);
  assign dma_chan       = chan_byte[7:4];
  assign feat_flags     = flag_byte;
  assign speed_code     = speed_byte;
  assign speed_tenths   = speed_rate(speed_byte);
  assign speed_known    = speed_listed(speed_byte);
  assign parity_en      = bus_bits[0];
  assign term_en        = bus_bits[1];
  assign boot_bus_reset = bus_bits[2];

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int unsigned NBYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_op,
  input  logic [7:0] cmd_off,
  input  logic [7:0] cmd_len,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       done,
  output logic [7:0] status,
  output logic [2:0] bus_id,
  output logic       alt_floppy,
  output logic [4:0] irq_num,
  output logic [3:0] dma_chan,
  output logic [7:0] feat_flags,
  output logic [7:0] speed_code,
  output logic [6:0] speed_tenths,
  output logic       speed_known,
  output logic       parity_en,
  output logic       term_en,
  output logic       boot_bus_reset
);

  localparam int unsigned AW = $clog2(NBYTES);

  logic          cmd_fire;
  logic          beat_fire;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    tap_id, tap_chan, tap_flags, tap_speed, tap_bus;

  cfg_store_seq #(.NBYTES(NBYTES)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_off   (cmd_off),
    .cmd_len   (cmd_len),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .done      (done),
    .status    (status),
    .cmd_fire  (cmd_fire),
    .beat_fire (beat_fire),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
  );

  cfg_store_image #(.NBYTES(NBYTES)) image_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (mem_we),
    .addr      (mem_addr),
    .wdata     (wr_data),
    .rdata     (rd_data),
    .tap_id    (tap_id),
    .tap_chan  (tap_chan),
    .tap_flags (tap_flags),
    .tap_speed (tap_speed),
    .tap_bus   (tap_bus)
  );

  logic [4:0] unused_bus;
  assign unused_bus = tap_bus[7:3];

  cfg_store_decode decode_i (
    .id_byte        (tap_id),
    .chan_byte      (tap_chan),
    .flag_byte      (tap_flags),
    .speed_byte     (tap_speed),
    .bus_bits       (tap_bus[2:0] | {2'b00, &unused_bus & 1'b0}),
    .bus_id         (bus_id),
    .alt_floppy     (alt_floppy),
    .irq_num        (irq_num),
    .dma_chan       (dma_chan),
    .feat_flags     (feat_flags),
    .speed_code     (speed_code),
    .speed_tenths   (speed_tenths),
    .speed_known    (speed_known),
    .parity_en      (parity_en),
    .term_en        (term_en),
    .boot_bus_reset (boot_bus_reset)
  );

endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int unsigned NBYTES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_op,
  input logic [7:0] cmd_off,
  input logic [7:0] cmd_len,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic [7:0] status,
  input logic [4:0] irq_num,
  input logic       mem_we,
  input logic       beat_fire
);

  logic [8:0] span_end;
  assign span_end = 9'(cmd_off) + 9'(cmd_len);

  // R3: an over-long span is refused in the next cycle
  assert_span_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (span_end > 9'(NBYTES))) |=> (done && status == 8'hFF));

  // R6: unknown opcode is refused in the next cycle
  assert_unknown_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 8'h22 && cmd_op != 8'h23) |=> (done && status == 8'hFF));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: no new command is offered ready while one is in progress
  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready || rd_valid || done) |-> !cmd_ready);

  // R4: the image is written only on a write handshake
  assert_store_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_valid && wr_ready && beat_fire));

  // R5: a stalled read byte is held
  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R10: interrupt number always lies in the coded range
  assert_irq_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_num >= 5'd9) && (irq_num <= 5'd24));

  // R2: the two data streams are never active together
  assert_one_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_ready, rd_valid, done}) <= 1);

endmodule

bind cfg_store cfg_store_chk #(.NBYTES(NBYTES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_off   (cmd_off),
  .cmd_len   (cmd_len),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .status    (status),
  .irq_num   (irq_num),
  .mem_we    (mem_we),
  .beat_fire (beat_fire)
);

// File: tb/cfg_store_tb_top.sv
`timescale 1ns/1ps
module cfg_store_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_op = '0, cmd_off = '0, cmd_len = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       done;
  logic [7:0] status;
  logic [2:0] bus_id;
  logic       alt_floppy;
  logic [4:0] irq_num;
  logic [3:0] dma_chan;
  logic [7:0] feat_flags, speed_code;
  logic [6:0] speed_tenths;
  logic       speed_known, parity_en, term_en, boot_bus_reset;

  always #2.5 clk = ~clk;

  cfg_store dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_off(cmd_off), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .status(status),
    .bus_id(bus_id), .alt_floppy(alt_floppy), .irq_num(irq_num),
    .dma_chan(dma_chan), .feat_flags(feat_flags), .speed_code(speed_code),
    .speed_tenths(speed_tenths), .speed_known(speed_known),
    .parity_en(parity_en), .term_en(term_en), .boot_bus_reset(boot_bus_reset)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] model [32];
  logic [7:0] wbuf [256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int rate_of(input logic [7:0] c);
    if (c == 8'h00) return 50;
    if (c == 8'h01) return 67;
    if (c == 8'h02) return 80;
    if (c == 8'h03) return 100;
    if (c == 8'h04) return 56;
    if (c == 8'hFF) return 33;
    return 0;
  endfunction

  function automatic int expect_status(input logic [7:0] op, input logic [7:0] off,
                                       input logic [7:0] len);
    if (int'(off) + int'(len) > 32) return 255;
    if (op == 8'h22) return 0;
    if (op == 8'h23) return int'(len);
    return 255;
  endfunction

  task automatic check_decode(input string tag);
    check(bus_id == model[0][2:0], {"R9 bus_id ", tag}, bus_id, model[0][2:0]);
    check(alt_floppy == model[0][7], {"R9 alt_floppy ", tag}, alt_floppy, model[0][7]);
    check(int'(irq_num) == int'(model[1] & 8'h0F) + 9, {"R10 irq ", tag}, irq_num,
          int'(model[1] & 8'h0F) + 9);
    check(dma_chan == model[1][7:4], {"R10 dma ", tag}, dma_chan, model[1][7:4]);
    check(feat_flags == model[2], {"R12 flags ", tag}, feat_flags, model[2]);
    check(speed_code == model[3], {"R11 code ", tag}, speed_code, model[3]);
    check(int'(speed_tenths) == rate_of(model[3]), {"R11 rate ", tag}, speed_tenths,
          rate_of(model[3]));
    check(speed_known == (rate_of(model[3]) != 0), {"R11 known ", tag}, speed_known,
          rate_of(model[3]) != 0);
    check({boot_bus_reset, term_en, parity_en} == model[6][2:0], {"R12 bus bits ", tag},
          {boot_bus_reset, term_en, parity_en}, model[6][2:0]);
  endtask

  // Issue one command; wbuf holds write data. Stalls are random.
  task automatic run_cmd(input logic [7:0] op, input logic [7:0] off, input logic [7:0] len);
    int st;
    st = expect_status(op, off, len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_off = off; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (st == 255 || len == 0) begin
      check(wr_ready == 1'b0 && rd_valid == 1'b0, "R3 no stream on refused/empty",
            {wr_ready, rd_valid}, 0);
    end else if (op == 8'h22) begin
      for (int i = 0; i < int'(len); i++) begin
        if ($urandom % 4 == 0) begin
          wr_valid = 1'b0;
          @(negedge clk);
        end
        check(wr_ready == 1'b1, "R4 wr_ready during store", wr_ready, 1);
        wr_valid = 1'b1; wr_data = wbuf[i];
        @(negedge clk);
        wr_valid = 1'b0;
        model[int'(off) + i] = wbuf[i];
        if (i + 1 < int'(len)) check_decode("R13 mid-store");
      end
    end else begin
      for (int i = 0; i < int'(len); i++) begin
        if ($urandom % 4 == 0) begin
          rd_ready = 1'b0;
          @(negedge clk);
        end
        check(rd_valid == 1'b1, "R5 rd_valid during fetch", rd_valid, 1);
        check(rd_data == model[int'(off) + i], "R5 fetched byte", rd_data,
              model[int'(off) + i]);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
      end
    end
    check(done == 1'b1, "R7 done in expected cycle", done, 1);
    check(int'(status) == st, (st == 255) ? "R3/R6 refused status" :
          (len == 0 ? "R8 empty status" : "R4/R5 status"), status, st);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check_decode("R13 after cmd");
  endtask

  task automatic read_all(input string tag);
    run_cmd(8'h23, 8'd0, 8'd32);
    tests++;
    if (0) $display("%s", tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    model[0] = 8'h07; model[1] = 8'h66; model[2] = 8'h22; model[6] = 8'h06;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && done == 1'b0, "R2 idle after reset", {cmd_ready, done}, 2);
    check_decode("R1 reset");
    check(irq_num == 5'd15 && dma_chan == 4'd6 && bus_id == 3'd7, "R1 defaults",
          {irq_num, dma_chan, bus_id}, {5'd15, 4'd6, 3'd7});
    read_all("R1 image");

    // Directed boundaries
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    run_cmd(8'h22, 8'd30, 8'd2);             // R4 last two bytes
    run_cmd(8'h23, 8'd30, 8'd2);             // R5
    run_cmd(8'h22, 8'd31, 8'd2);             // R3 one past the end
    run_cmd(8'h23, 8'd0, 8'd33);             // R3
    run_cmd(8'h22, 8'd32, 8'd0);             // R8 empty at end
    run_cmd(8'h23, 8'd5, 8'd0);              // R8
    run_cmd(8'h22, 8'd33, 8'd0);             // R3 empty but out of range
    run_cmd(8'h24, 8'd0, 8'd1);              // R6
    run_cmd(8'h23, 8'd250, 8'd10);           // R3 wrap of the 8-bit sum
    read_all("R3 R6 unchanged");

    // Speed codes, IRQ and flags
    for (int c = 0; c < 8; c++) begin
      wbuf[0] = (c == 7) ? 8'hFF : 8'(c);
      run_cmd(8'h22, 8'd3, 8'd1);            // R11
    end
    wbuf[0] = 8'h8D; wbuf[1] = 8'h3F; wbuf[2] = 8'hC3;
    run_cmd(8'h22, 8'd0, 8'd3);              // R9 R10 R12
    wbuf[0] = 8'h05;
    run_cmd(8'h22, 8'd6, 8'd1);              // R12

    // Random commands
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op, off, len;
      int pick;
      pick = $urandom % 8;
      op = (pick < 4) ? 8'h22 : (pick < 7) ? 8'h23 : 8'($urandom);
      off = 8'($urandom % 40);
      if ($urandom % 4 != 0 && off <= 8'd32) len = 8'($urandom % (33 - int'(off)));
      else len = 8'($urandom % 40);
      for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
      run_cmd(op, off, len);
    end
    read_all("final image");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule